// File: doc/BRIEF.md
# Interprocessor Interrupt Source Controller

This block arbitrates among four software-triggered interrupt sources that share one interrupt line to a processor. Each source has a configuration word holding a mask bit, a 4-bit priority, an 8-bit vector and a read-only activity flag. Software raises a source by writing a dispatch word: every set bit among the low four marks the matching source pending. The block presents the best eligible source on a registered `irq` output. A source is eligible when it is pending, unmasked, has a non-zero priority, and has a priority above every source now in service.

The processor takes an interrupt by reading the acknowledge address. That read returns the chosen source's vector and moves the source from pending to in-service. If no source is eligible, the read returns the spurious code 0xFF and changes nothing. A write to the end-of-interrupt address retires the in-service source with the highest priority. A pending request that arrives while its source is masked is kept, and it is raised as soon as the mask is cleared.

Register pages sit 0x10 bytes apart, and the page number is taken from address bits [6:4]. Pages 0 to 3 hold the source configuration words, page 4 (0x40) is dispatch, page 5 (0x50) is acknowledge, and page 6 (0x60) is end-of-interrupt. Reads return their data one cycle after `rd_en`.

Top module: `ipi_src_ctrl`

## Requirements
- R1: After reset every configuration word reads 0x8000_0000 (mask bit 31 set; activity, priority and vector zero), no source is pending or in service, and `irq` is 0.
- R2: In a configuration word, mask (bit 31), priority (bits 19:16) and vector (bits 7:0) can be written and read back. Every other bit reads 0, and a write to the activity bit (bit 30) has no effect.
- R3: A write to 0x40 with bit i of the data set marks source i pending. The activity bit of a source reads 1 while it is pending or in service.
- R4: A pending source whose mask bit is set is never presented, and `irq` stays 0 for it. Clearing the mask while the source is still pending makes it presented.
- R5: A source with priority 0 is never presented, even when it is pending and unmasked.
- R6: Among eligible sources the one with the highest priority is presented, and on equal priority the lower-numbered source wins. A read of 0x50 returns that source's vector in bits 7:0, with zeros above.
- R7: The acknowledge read moves the presented source from pending to in service, so its activity bit stays 1. A write to 0x60 retires the in-service source with the highest priority, and its activity bit then reads 0 unless it is pending again.
- R8: A pending source is presented only if its priority is strictly above the priority of every source in service.
- R9: When no source is eligible, a read of 0x50 returns 0x0000_00FF and changes no source state.
- R10: While a source's activity bit is 1, writes to its configuration word leave priority and vector unchanged, but the mask bit is still written.
- R11: `irq` is registered. It shows the eligibility that results from a write or an acknowledge on the clock edge after the one that commits that write or acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write byte address; page in bits 6:4 |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 7 | Read byte address; page in bits 6:4 |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a source that is pending, unmasked and has a non-zero priority, yet is held back because another source of equal or higher priority is in service. The bench reaches it by configuring two sources and dispatching both, then acknowledging once so that the winner goes into service. A second acknowledge must then return the spurious code. The bench sweeps every priority pair for the two sources and, after end-of-interrupt, checks that the source held back is presented only when its own priority is non-zero.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  // Field positions inside a source configuration word.
  localparam int MASK_BIT = 31;
  localparam int ACT_BIT  = 30;
  localparam int PRIO_LSB = 16;
  localparam int VEC_LSB  = 0;
  // Address pages (address bits [6:4]).
  localparam int PG_LSB = 4;
  localparam logic [2:0] PG_DISPATCH = 3'd4;
  localparam logic [2:0] PG_ACK      = 3'd5;
  localparam logic [2:0] PG_EOI      = 3'd6;
endpackage

// File: rtl/ipi_slot.sv
module ipi_slot #(
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              wr_mask,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic [VEC_W-1:0]  wr_vec,
  input  logic              fire,
  input  logic              take,
  input  logic              retire,
  output logic              mask,
  output logic [PRIO_W-1:0] prio,
  output logic [VEC_W-1:0]  vec,
  output logic              pend,
  output logic              insvc
);
  logic active;
  assign active = pend | insvc;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask  <= 1'b1;
      prio  <= '0;
      vec   <= '0;
      pend  <= 1'b0;
      insvc <= 1'b0;
    end else begin
      if (cfg_we) begin
        mask <= wr_mask;
        if (!active) begin
          prio <= wr_prio;
          vec  <= wr_vec;
        end
      end
      if (fire)      pend <= 1'b1;
      else if (take) pend <= 1'b0;
      if (take)        insvc <= 1'b1;
      else if (retire) insvc <= 1'b0;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (mask && prio == '0 && vec == '0 && !pend && !insvc));

  p_frozen_when_active_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && active) |=> ($stable(prio) && $stable(vec)));
endmodule

// File: rtl/ipi_pick.sv
module ipi_pick #(
  parameter int NSRC   = 4,
  parameter int PRIO_W = 4,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NSRC-1:0]              mask,
  input  logic [NSRC-1:0]              pend,
  input  logic [NSRC-1:0]              insvc,
  input  logic [NSRC-1:0][PRIO_W-1:0]  prio,
  output logic                         any_elig,
  output logic [SEL_W-1:0]             sel,
  output logic                         any_insvc,
  output logic [SEL_W-1:0]             eoi_sel
);
  logic [PRIO_W-1:0] isr_max;
  logic [PRIO_W-1:0] best;
  logic [NSRC-1:0]   elig;

  always_comb begin
    any_insvc = 1'b0;
    isr_max   = '0;
    eoi_sel   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (insvc[i] && (!any_insvc || prio[i] > isr_max)) begin
        any_insvc = 1'b1;
        isr_max   = prio[i];
        eoi_sel   = SEL_W'(i);
      end
    end
    any_elig = 1'b0;
    best     = '0;
    sel      = '0;
    for (int i = 0; i < NSRC; i++) begin
      elig[i] = pend[i] && !mask[i] && (prio[i] != '0) && (prio[i] > isr_max);
      if (elig[i] && (!any_elig || prio[i] > best)) begin
        any_elig = 1'b1;
        best     = prio[i];
        sel      = SEL_W'(i);
      end
    end
  end

  p_sel_unmasked_pending_r4: assert property (@(posedge clk) disable iff (rst)
    any_elig |-> (!mask[sel] && pend[sel]));

  p_sel_nonzero_prio_r5: assert property (@(posedge clk) disable iff (rst)
    any_elig |-> (prio[sel] != '0));
endmodule

// File: rtl/ipi_src_ctrl.sv
module ipi_src_ctrl #(
  parameter int NSRC   = 4,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  import ipi_pkg::*;
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [2:0] wr_pg, rd_pg;
  assign wr_pg = wr_addr[PG_LSB +: 3];
  assign rd_pg = rd_addr[PG_LSB +: 3];

  logic unused_bits;
  assign unused_bits = ^{wr_data, wr_addr, rd_addr};

  logic                        ack_rd, eoi_wr;
  logic [NSRC-1:0]             mask, pend, insvc;
  logic [NSRC-1:0][PRIO_W-1:0] prio;
  logic [VEC_W-1:0]            vec [NSRC];
  logic [DATA_W-1:0]           cfg_word [NSRC];
  logic                        any_elig, any_insvc;
  logic [SEL_W-1:0]            sel, eoi_sel;

  assign ack_rd = rd_en && (rd_pg == PG_ACK);
  assign eoi_wr = wr_en && (wr_pg == PG_EOI);

  for (genvar i = 0; i < NSRC; i++) begin : g_slot
    logic cfg_we, fire, take, retire;
    assign cfg_we = wr_en && (wr_pg == 3'(i));
    assign fire   = wr_en && (wr_pg == PG_DISPATCH) && wr_data[i];
    assign take   = ack_rd && any_elig && (sel == SEL_W'(i));
    assign retire = eoi_wr && any_insvc && (eoi_sel == SEL_W'(i));

    ipi_slot #(.PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_slot (
      .clk(clk), .rst(rst), .cfg_we(cfg_we),
      .wr_mask(wr_data[MASK_BIT]),
      .wr_prio(wr_data[PRIO_LSB +: PRIO_W]),
      .wr_vec(wr_data[VEC_LSB +: VEC_W]),
      .fire(fire), .take(take), .retire(retire),
      .mask(mask[i]), .prio(prio[i]), .vec(vec[i]),
      .pend(pend[i]), .insvc(insvc[i])
    );

    always_comb begin
      cfg_word[i]                     = '0;
      cfg_word[i][MASK_BIT]           = mask[i];
      cfg_word[i][ACT_BIT]            = pend[i] | insvc[i];
      cfg_word[i][PRIO_LSB +: PRIO_W] = prio[i];
      cfg_word[i][VEC_LSB +: VEC_W]   = vec[i];
    end
  end

  ipi_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_pick (
    .clk(clk), .rst(rst), .mask(mask), .pend(pend), .insvc(insvc),
    .prio(prio), .any_elig(any_elig), .sel(sel),
    .any_insvc(any_insvc), .eoi_sel(eoi_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= any_elig;
      if (rd_en) begin
        if (rd_pg < 3'(NSRC))
          rd_data <= cfg_word[rd_pg[SEL_W-1:0]];
        else if (rd_pg == PG_ACK)
          rd_data <= any_elig ? DATA_W'(vec[sel]) : DATA_W'({VEC_W{1'b1}});
        else
          rd_data <= '0;
      end
    end
  end

  p_ack_vector_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && any_elig) |=> (rd_data == DATA_W'($past(vec[sel]))));

  p_ack_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && !any_elig) |=> (rd_data == DATA_W'({VEC_W{1'b1}}) && $stable(pend) && $stable(insvc)));

  p_eoi_retires_r7: assert property (@(posedge clk) disable iff (rst)
    (eoi_wr && any_insvc) |=> !insvc[$past(eoi_sel)]);
endmodule

// File: tb/sim_ipi_src_ctrl.sv
`timescale 1ns/1ps
module sim_ipi_src_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  ipi_src_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  localparam logic [6:0] A_DISP = 7'h40, A_ACK = 7'h50, A_EOI = 7'h60;

  function automatic logic [31:0] cw(input logic m, input logic a, input logic [3:0] p, input logic [7:0] v);
    return {m, a, 10'b0, p, 8'b0, v};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    @(negedge clk);
    check(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  pp [4];
    do_reset();

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      rd(7'(i * 16), d);
      check("R1 reset word", d, 32'h8000_0000);
    end
    check("R1 reset irq", {31'b0, irq}, 32'b0);

    // R2: field read/write, other bits read zero, activity not writable
    wr(7'h20, 32'hFFFF_FFFF);
    rd(7'h20, d);
    check("R2 all ones", d, 32'h800F_00FF);
    wr(7'h20, 32'h0003_0042);
    rd(7'h20, d);
    check("R2 fields", d, 32'h0003_0042);

    // R3/R4/R10/R7: masked pending held, fires on unmask
    wr(7'h00, cw(1, 0, 4'd5, 8'h21));
    wr(A_DISP, 32'h1);
    rd(7'h00, d);
    check("R3 act set", d, cw(1, 1, 4'd5, 8'h21));
    chk_irq("R4 masked no irq", 1'b0);
    rd(A_ACK, d);
    check("R4 R9 masked ack spurious", d, 32'h0000_00FF);
    wr(7'h00, cw(0, 0, 4'd9, 8'hAA));
    rd(7'h00, d);
    check("R10 prio/vec frozen, mask written", d, cw(0, 1, 4'd5, 8'h21));
    chk_irq("R4 unmask fires", 1'b1);
    rd(A_ACK, d);
    check("R6 ack vector", d, 32'h0000_0021);
    chk_irq("R7 irq drops after ack", 1'b0);
    rd(7'h00, d);
    check("R7 act in service", d, cw(0, 1, 4'd5, 8'h21));
    wr(A_EOI, 32'h0);
    rd(7'h00, d);
    check("R7 act clear after eoi", d, cw(0, 0, 4'd5, 8'h21));

    // R11: irq one edge after the committing edge
    do_reset();
    wr(7'h10, cw(0, 0, 4'd3, 8'h33));
    wr(A_DISP, 32'h2);
    check("R11 irq not yet", {31'b0, irq}, 32'b0);
    chk_irq("R11 irq next edge", 1'b1);

    // R6: every dispatch pattern, ties to lower index
    pp[0] = 4'd3; pp[1] = 4'd3; pp[2] = 4'd7; pp[3] = 4'd7;
    for (int pat = 1; pat < 16; pat++) begin
      int w;
      do_reset();
      for (int i = 0; i < 4; i++) wr(7'(i * 16), cw(0, 0, pp[i], 8'(8'h50 + i)));
      wr(A_DISP, 32'(pat));
      w = -1;
      for (int i = 0; i < 4; i++)
        if (pat[i] && (w < 0 || pp[i] > pp[w])) w = i;
      rd(A_ACK, d);
      check("R6 pattern winner", d, 32'(8'h50 + w));
    end

    // R5/R6/R7/R8/R9: full priority-pair sweep on two sources
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int w, o;
        int pr [2];
        pr[0] = a; pr[1] = b;
        do_reset();
        wr(7'h00, cw(0, 0, 4'(a), 8'hA0));
        wr(7'h10, cw(0, 0, 4'(b), 8'hB1));
        wr(A_DISP, 32'h3);
        chk_irq("R5 irq only with nonzero prio", (a != 0) || (b != 0));
        if (a == 0 && b == 0) w = -1;
        else if (a != 0 && (b == 0 || a >= b)) w = 0;
        else w = 1;
        rd(A_ACK, d);
        check("R5 R6 R9 first ack", d, (w < 0) ? 32'hFF : (w == 0 ? 32'hA0 : 32'hB1));
        rd(A_ACK, d);
        check("R8 blocked by in-service", d, 32'hFF);
        wr(A_EOI, 32'h0);
        o = (w == 0) ? 1 : 0;
        rd(A_ACK, d);
        check("R7 after eoi", d, (w >= 0 && pr[o] != 0) ? (o == 0 ? 32'hA0 : 32'hB1) : 32'hFF);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule